// File: doc/BRIEF.md
# Low-Power Mode Sequencer with Clock-Enable Generation

This block decides which clocks of a small controller system run. It follows the CPU through three operating states: a running state, a light sleep in which only the processor clock halts, and a deep sleep in which nearly every clock halts. Two control bits decide which sleep a wait-for-interrupt strobe selects: a deep-sleep request and a power-down permit. A vector of per-source wake-up events brings the system back. In light sleep any event wakes it. In deep sleep only a fixed group of sources that can still be clocked wakes it.

The clock enables leave the block from registers. On the way back from either sleep there is one cycle of resume. In that cycle the fast oscillators and the peripheral clocks already run and the processor clock stays off. The processor clock returns one cycle later. While in deep sleep, the watchdog, timer and serial-port clocks each stay on only when that peripheral's own source select names a slow oscillator. The slow oscillators are never gated by this block.

Top module: `pmc_lp_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `mode_o` is 0 (running) and every clock-enable output is 1.
- R2: A `wfi_i` pulse seen in the running state with `deep_sleep_i`=0 and `pd_permit_i`=0 gives `mode_o`=1 (light sleep) in the next cycle.
- R3: A `wfi_i` pulse seen in the running state with both control bits at 1 gives `mode_o`=2 (deep sleep) in the next cycle.
- R4: A `wfi_i` pulse with exactly one of the two control bits set gives light sleep (`mode_o`=1), not deep sleep.
- R5: In light sleep `cpu_clk_en_o` is 0, while `fast_clk_en_o`, `slow_clk_en_o` and all bits of `periph_clk_en_o` are 1.
- R6: In deep sleep `cpu_clk_en_o`, both `fast_clk_en_o` bits and `periph_clk_en_o` bits 3 and up are 0, and `slow_clk_en_o` is 2'b11.
- R7: In deep sleep, `periph_clk_en_o` bit 0 (watchdog), bit 1 (timer) and bit 2 (serial port) each equal bit 1 of that peripheral's 2-bit source select (encoding: 0 fast crystal, 1 fast RC, 2 slow crystal, 3 slow RC). A change of select shows one cycle later.
- R8: In light sleep, any set bit of `wake_src_i` gives `mode_o`=3 (resume) in the next cycle.
- R9: In deep sleep, only `wake_src_i` bits 0 to 8 wake the block (watchdog, timer, serial port, brown-out, GPIO, external pin, synchronous serial, CAN, comparator). Bits 9 and up leave the mode and all enables unchanged.
- R10: In the resume cycle (`mode_o`=3) the fast enables and all peripheral enables are 1 and `cpu_clk_en_o` is 0. In the cycle after it `mode_o` is 0 and `cpu_clk_en_o` is 1.
- R11: `wfi_i` has no effect outside the running state. With no wake event, light sleep stays light sleep whatever the control bits are.
- R12: `slow_clk_en_o` is 2'b11 in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst | input | 1 | Synchronous active-high reset |
| deep_sleep_i | input | 1 | Deep-sleep request bit |
| pd_permit_i | input | 1 | Power-down permit bit |
| wfi_i | input | 1 | Wait-for-interrupt strobe from the CPU |
| wake_src_i | input | NUM_SRC | Per-source wake-up events, bit order as in R9 |
| wdt_sel_i | input | 2 | Watchdog clock-source select |
| tmr_sel_i | input | 2 | Timer clock-source select |
| uart_sel_i | input | 2 | Serial-port clock-source select |
| cpu_clk_en_o | output | 1 | Processor clock enable |
| fast_clk_en_o | output | 2 | Enables for the fast crystal (bit 0) and fast RC (bit 1) |
| slow_clk_en_o | output | 2 | Enables for the slow crystal (bit 0) and slow RC (bit 1) |
| periph_clk_en_o | output | NUM_PERIPH | Peripheral clock enables; bits 0..2 are watchdog, timer, serial port |
| mode_o | output | 2 | 0 running, 1 light sleep, 2 deep sleep, 3 resume |

## Verification
The bench tries all four combinations of the two control bits on entry, which separates the single-bit cases (light sleep) from the both-set case (deep sleep). In deep sleep it walks all 64 combinations of the three source selects, so that each peripheral enable is shown to follow its own select and no other. Each wake-up bit is then raised alone, once in light sleep and once in deep sleep. This separates the permitted group from the ignored bits and checks the two-step resume order every time. Stray strobes while asleep show that the mode holds.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        PM_RUN    = 2'd0,
        PM_IDLE   = 2'd1,
        PM_DOWN   = 2'd2,
        PM_RESUME = 2'd3
    } pm_mode_e;

    typedef enum logic [1:0] {
        SRC_FAST_XTAL = 2'd0,
        SRC_FAST_RC   = 2'd1,
        SRC_SLOW_XTAL = 2'd2,
        SRC_SLOW_RC   = 2'd3
    } clk_src_e;

    localparam int SEL_W = 2;

    // wake-source bit positions; the first WK_DOWN_CNT may wake deep sleep
    localparam int WK_WDT      = 0;
    localparam int WK_TMR      = 1;
    localparam int WK_UART     = 2;
    localparam int WK_BROWNOUT = 3;
    localparam int WK_GPIO     = 4;
    localparam int WK_EXTPIN   = 5;
    localparam int WK_SSER     = 6;
    localparam int WK_CAN      = 7;
    localparam int WK_CMP      = 8;
    localparam int WK_DOWN_CNT = 9;

    // peripheral clock positions that may run from a slow source
    localparam int PER_WDT    = 0;
    localparam int PER_TMR    = 1;
    localparam int PER_UART   = 2;
    localparam int PER_SLOWOK = 3;

    typedef struct packed {
        logic       cpu;
        logic [1:0] fast;
        logic [1:0] slow;
    } core_en_t;

    function automatic logic src_is_slow(input logic [SEL_W-1:0] sel);
        return (sel == SRC_SLOW_XTAL) || (sel == SRC_SLOW_RC);
    endfunction

    function automatic core_en_t core_decode(input pm_mode_e m);
        core_en_t c;
        c.cpu  = (m == PM_RUN);
        c.fast = (m == PM_DOWN) ? 2'b00 : 2'b11;
        c.slow = 2'b11;
        return c;
    endfunction

endpackage

// File: rtl/pmc_wake_filter.sv
module pmc_wake_filter
    import pmc_pkg::*;
#(
    parameter int NUM_SRC = 12
) (
    input  pm_mode_e             mode_i,
    input  logic [NUM_SRC-1:0]   wake_src_i,
    output logic                 wake_go_o
);
    localparam int DOWN_N = (WK_DOWN_CNT < NUM_SRC) ? WK_DOWN_CNT : NUM_SRC;

    logic [NUM_SRC-1:0] down_mask;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_mask
        if (i < DOWN_N) begin : g_on
            assign down_mask[i] = 1'b1;
        end else begin : g_off
            assign down_mask[i] = 1'b0;
        end
    end

    logic any_idle, any_down;
    assign any_idle = |wake_src_i;
    assign any_down = |(wake_src_i & down_mask);

    always_comb begin
        case (mode_i)
            PM_IDLE: wake_go_o = any_idle;
            PM_DOWN: wake_go_o = any_down;
            default: wake_go_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
    import pmc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     deep_i,
    input  logic     permit_i,
    input  logic     wfi_i,
    input  logic     wake_go_i,
    output pm_mode_e mode_q_o,
    output pm_mode_e mode_d_o
);
    pm_mode_e mode_q, mode_d;

    always_comb begin
        mode_d = mode_q;
        case (mode_q)
            PM_RUN: begin
                if (wfi_i) mode_d = (deep_i && permit_i) ? PM_DOWN : PM_IDLE;
            end
            PM_IDLE, PM_DOWN: begin
                if (wake_go_i) mode_d = PM_RESUME;
            end
            default: mode_d = PM_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= PM_RUN;
        else     mode_q <= mode_d;
    end

    assign mode_q_o = mode_q;
    assign mode_d_o = mode_d;

    // R3
    deep_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_RUN && wfi_i && deep_i && permit_i) |=> (mode_q == PM_DOWN));

    // R4
    light_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_RUN && wfi_i && !(deep_i && permit_i)) |=> (mode_q == PM_IDLE));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_IDLE && !wake_go_i) |=> (mode_q == PM_IDLE));

    // R10
    resume_next_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_RESUME) |=> (mode_q == PM_RUN));

endmodule

// File: rtl/pmc_clk_en_gen.sv
module pmc_clk_en_gen
    import pmc_pkg::*;
#(
    parameter int NUM_PERIPH = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  pm_mode_e              mode_q_i,
    input  pm_mode_e              mode_d_i,
    input  logic [SEL_W-1:0]      wdt_sel_i,
    input  logic [SEL_W-1:0]      tmr_sel_i,
    input  logic [SEL_W-1:0]      uart_sel_i,
    output core_en_t              core_en_o,
    output logic [NUM_PERIPH-1:0] per_en_o
);
    logic [PER_SLOWOK-1:0][SEL_W-1:0] sel;
    assign sel[PER_WDT]  = wdt_sel_i;
    assign sel[PER_TMR]  = tmr_sel_i;
    assign sel[PER_UART] = uart_sel_i;

    core_en_t              core_d, core_q;
    logic [NUM_PERIPH-1:0] per_d, per_q;

    assign core_d = core_decode(mode_d_i);

    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_per
        if (i < PER_SLOWOK) begin : g_slowok
            assign per_d[i] = (mode_d_i != PM_DOWN) || src_is_slow(sel[i]);
        end else begin : g_fastonly
            assign per_d[i] = (mode_d_i != PM_DOWN);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q <= '{cpu: 1'b1, fast: 2'b11, slow: 2'b11};
            per_q  <= '1;
        end else begin
            core_q <= core_d;
            per_q  <= per_d;
        end
    end

    assign core_en_o = core_q;
    assign per_en_o  = per_q;

    // R5
    idle_clocks_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q_i == PM_IDLE) |-> (!core_q.cpu && core_q.fast == 2'b11 && (&per_q)));

    // R6
    down_clocks_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q_i == PM_DOWN) |-> (!core_q.cpu && core_q.fast == 2'b00
                                   && core_q.slow == 2'b11 && ((per_q >> PER_SLOWOK) == '0)));

    // R10
    cpu_after_fast_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(core_q.cpu) |-> ($past(core_q.fast) == 2'b11 && mode_q_i == PM_RUN));

    // R10
    resume_clocks_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q_i == PM_RESUME) |-> (!core_q.cpu && core_q.fast == 2'b11 && (&per_q)));

endmodule

// File: rtl/pmc_lp_ctrl.sv
module pmc_lp_ctrl
    import pmc_pkg::*;
#(
    parameter int NUM_SRC    = 12,
    parameter int NUM_PERIPH = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  deep_sleep_i,
    input  logic                  pd_permit_i,
    input  logic                  wfi_i,
    input  logic [NUM_SRC-1:0]    wake_src_i,
    input  logic [1:0]            wdt_sel_i,
    input  logic [1:0]            tmr_sel_i,
    input  logic [1:0]            uart_sel_i,
    output logic                  cpu_clk_en_o,
    output logic [1:0]            fast_clk_en_o,
    output logic [1:0]            slow_clk_en_o,
    output logic [NUM_PERIPH-1:0] periph_clk_en_o,
    output logic [1:0]            mode_o
);
    localparam int DOWN_N = (WK_DOWN_CNT < NUM_SRC) ? WK_DOWN_CNT : NUM_SRC;

    pm_mode_e mode_q, mode_d;
    logic     wake_go;
    core_en_t core_en;

    pmc_wake_filter #(.NUM_SRC(NUM_SRC)) u_wake (
        .mode_i     (mode_q),
        .wake_src_i (wake_src_i),
        .wake_go_o  (wake_go)
    );

    pmc_mode_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .deep_i    (deep_sleep_i),
        .permit_i  (pd_permit_i),
        .wfi_i     (wfi_i),
        .wake_go_i (wake_go),
        .mode_q_o  (mode_q),
        .mode_d_o  (mode_d)
    );

    pmc_clk_en_gen #(.NUM_PERIPH(NUM_PERIPH)) u_clk (
        .clk        (clk),
        .rst        (rst),
        .mode_q_i   (mode_q),
        .mode_d_i   (mode_d),
        .wdt_sel_i  (wdt_sel_i),
        .tmr_sel_i  (tmr_sel_i),
        .uart_sel_i (uart_sel_i),
        .core_en_o  (core_en),
        .per_en_o   (periph_clk_en_o)
    );

    assign cpu_clk_en_o  = core_en.cpu;
    assign fast_clk_en_o = core_en.fast;
    assign slow_clk_en_o = core_en.slow;
    assign mode_o        = mode_q;

    // R9
    down_wake_src_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_q) == PM_DOWN && mode_q == PM_RESUME)
            |-> ($past(|wake_src_i[DOWN_N-1:0])));

    // R8
    idle_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_IDLE && (|wake_src_i)) |=> (mode_q == PM_RESUME));

endmodule

// File: tb/pmc_lp_ctrl_tb_top.sv
module pmc_lp_ctrl_tb_top;

    localparam int NS = 12;
    localparam int NP = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          deep = 1'b0, permit = 1'b0, wfi = 1'b0;
    logic [NS-1:0] wake = '0;
    logic [1:0]    wsel = 2'd0, tsel = 2'd0, usel = 2'd0;
    logic          cpu_en;
    logic [1:0]    fast_en, slow_en, mode;
    logic [NP-1:0] per_en;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    pmc_lp_ctrl #(.NUM_SRC(NS), .NUM_PERIPH(NP)) dut_i (
        .clk             (clk),
        .rst             (rst),
        .deep_sleep_i    (deep),
        .pd_permit_i     (permit),
        .wfi_i           (wfi),
        .wake_src_i      (wake),
        .wdt_sel_i       (wsel),
        .tmr_sel_i       (tsel),
        .uart_sel_i      (usel),
        .cpu_clk_en_o    (cpu_en),
        .fast_clk_en_o   (fast_en),
        .slow_clk_en_o   (slow_en),
        .periph_clk_en_o (per_en),
        .mode_o          (mode)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected below 50000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // packs all outputs: {mode, cpu, fast, slow, periph}
    function automatic logic [6+NP:0] expect_for(input logic [1:0] m);
        logic          c;
        logic [1:0]    f;
        logic [NP-1:0] p;
        c = (m == 2'd0);
        f = (m == 2'd2) ? 2'b00 : 2'b11;
        p = '1;
        if (m == 2'd2) begin
            p = '0;
            p[0] = wsel[1];
            p[1] = tsel[1];
            p[2] = usel[1];
        end
        return {m, c, f, 2'b11, p};
    endfunction

    task automatic check(input string req, input logic [1:0] m);
        logic [6+NP:0] act, exp;
        act = {mode, cpu_en, fast_en, slow_en, per_en};
        exp = expect_for(m);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%b expected=%b (mode,cpu,fast,slow,periph)", req, act, exp);
        end
    endtask

    task automatic enter(input logic d, input logic p);
        deep = d; permit = p; wfi = 1'b1;
        step();
        wfi = 1'b0; deep = 1'b0; permit = 1'b0;
    endtask

    task automatic wake_bit(input int b);
        wake = '0;
        wake[b] = 1'b1;
        step();
        wake = '0;
    endtask

    initial begin
        @(negedge clk);
        check("R1 reset held", 2'd0);
        step(); step();
        rst = 1'b0;
        check("R1 after reset", 2'd0);
        step();
        check("R1 first run cycle", 2'd0);

        // R2 R3 R4: all four control-bit combinations
        for (int k = 0; k < 4; k++) begin
            logic d, p;
            d = k[1]; p = k[0];
            enter(d, p);
            if (d && p) check("R3 deep entry", 2'd2);
            else if (d || p) check("R4 mismatch gives light sleep", 2'd1);
            else check("R2 light entry R5", 2'd1);
            wake_bit(4);
            check("R10 resume cycle", 2'd3);
            step();
            check("R10 cpu back", 2'd0);
        end

        // R11: strobes while asleep
        enter(1'b0, 1'b0);
        deep = 1'b1; permit = 1'b1; wfi = 1'b1;
        step();
        wfi = 1'b0; deep = 1'b0; permit = 1'b0;
        check("R11 wfi ignored in light sleep", 2'd1);
        step();
        check("R5 light sleep holds R12", 2'd1);
        wake_bit(11);
        check("R8 high bit wakes light sleep", 2'd3);
        step();

        // R7: all 64 select combinations in deep sleep
        enter(1'b1, 1'b1);
        for (int s = 0; s < 64; s++) begin
            wsel = s[1:0]; tsel = s[3:2]; usel = s[5:4];
            step();
            check("R7 select sweep R6", 2'd2);
        end
        wfi = 1'b1; deep = 1'b0; permit = 1'b0;
        step();
        wfi = 1'b0;
        check("R11 wfi ignored in deep sleep", 2'd2);
        wake_bit(0);
        step();
        wsel = 2'd3; tsel = 2'd0; usel = 2'd2;

        // R8: each bit wakes light sleep
        for (int b = 0; b < NS; b++) begin
            enter(1'b1, 1'b0);
            check("R4 light entry", 2'd1);
            wake_bit(b);
            check("R8 wake from light sleep", 2'd3);
            step();
            check("R10 return to run", 2'd0);
        end

        // R9: each bit in deep sleep
        for (int b = 0; b < NS; b++) begin
            enter(1'b1, 1'b1);
            check("R3 deep entry", 2'd2);
            wake_bit(b);
            if (b < 9) begin
                check("R9 permitted source wakes R10", 2'd3);
                step();
                check("R10 cpu returns after fast", 2'd0);
            end else begin
                check("R9 ignored source", 2'd2);
                step();
                check("R9 still asleep R12", 2'd2);
                wake_bit(8);
                check("R9 comparator wakes", 2'd3);
                step();
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule